// File: doc/BRIEF.md
# Byte-Wide Serial Port Controller

This block is a small asynchronous serial port with an 8-bit register bus. It sends and receives fixed-format characters: one start bit, eight data bits with the least significant bit first, and one stop bit. There is no parity and there are no modem or flow-control lines. Software sees eight byte registers, each on a word-aligned address. Four of them are read-only identification bytes. The others are a data port, a combined status and control register, and the two halves of a 16-bit baud divisor.

A tick generator divides the clock by (divisor + 1) to make a tick at four times the bit rate. Each serial bit lasts four ticks. Software computes the divisor as clk/(baud*4) - 1.

The transmitter has one holding slot in front of its shift register. The receiver puts characters into a four-entry FIFO. Software can read several characters from it in one interrupt, stopping when the empty flag rises. A single interrupt line reports both receive events and transmit events.

Transmit FSM states:
- `TX_IDLE`: the line is held high. On a tick, if the holding slot is full, the FSM moves to `TX_START` and loads the shifter.
- `TX_START`: after four ticks it moves to `TX_DATA`.
- `TX_DATA`: it shifts out eight bits. After the eighth bit's four ticks it moves to `TX_STOP`.
- `TX_STOP`: after four ticks it returns to `TX_IDLE`.

Receive FSM states:
- `RX_IDLE`: a tick sample that is low after a high sample moves the FSM to `RX_START`.
- `RX_START`: on the next tick, a high line means a false start and the FSM returns to `RX_IDLE`. A low line moves it to `RX_DATA`.
- `RX_DATA`: it samples one bit every fourth tick. After eight bits it moves to `RX_STOP`.
- `RX_STOP`: on the fourth tick it samples the stop bit, delivers the character and returns to `RX_IDLE`.

Top module: `byte_uart`

## Requirements
- R1: Register index is bus_addr[4:2] and only bus_addr[1:0]==0 is decoded. Index 0..3 are the identification bytes ID_WORD[7:0], [15:8], [23:16] and [31:24]; the default ID_WORD is 32'h5A3C01A7. Index 4 is data, 5 is status, 6 is divisor low and 7 is divisor high. A misaligned address reads 0.
- R2: After reset, status reads 0xA0, irq is 0 and txd is 1. The divisor resets to RESET_DIV (default 3).
- R3: The divisor is {high,low}. Each serial bit lasts 4*(divisor+1) clock cycles, and both divisor registers read back what was written.
- R4: A transmitted frame is a 0 start bit, eight data bits LSB first, then a 1 stop bit. The line stays high while the transmitter is idle.
- R5: Writing data fills the single holding slot and clears status bit 7. Bit 7 rises again once the shifter takes the character. A data write while bit 7 is 0 is ignored.
- R6: Received characters enter a four-entry FIFO. Reading data pops the oldest character. Status bit 5 means empty, bit 4 means exactly one free slot, and bit 3 means full.
- R7: A character that completes while the FIFO is full and not being read is discarded, sets status bit 1 (overrun), and leaves the stored characters intact.
- R8: A character whose stop bit samples 0 is still stored and sets status bit 0 (frame error).
- R9: Writing status with bit 0 or bit 1 at 0 clears that error flag, and writing 1 never sets it. Bits 2 (receive enable) and 6 (transmit enable) take the written value. Writes to bits 3, 4, 5 and 7 are ignored.
- R10: irq = (bit2 AND (FIFO not empty OR bit0 OR bit1)) OR (bit6 AND bit7).
- R11: A low pulse shorter than half a bit that is seen on only one tick is rejected as a false start, and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of the data register pops the FIFO |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined receive and transmit interrupt |

## Verification
Register reads are combinational, so the bench samples read data at the falling edge while the strobe is high. A pop takes effect at the rising edge that follows. A data write makes status bit 7 read 0 at the very next falling edge. The shifter can take the character no earlier than the next tick, which is at most divisor+1 cycles later, so the bench polls for that instead of assuming a cycle count.

A transmitted frame starts on a tick edge and each bit holds for exactly 4*(divisor+1) cycles. The bench therefore finds the falling start edge, then samples each bit at its middle (7.5 cycles after the edge, plus 16 cycles per bit), and counts the start bit's low cycles directly.

A received character reaches the FIFO and the status flags about 9.5 bit times after its start edge. The bench keeps driving idle for a full bit after the stop bit before it reads status, data or irq. That leaves a margin of more than half a bit in every case.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Register indices (address bits [4:2])
    localparam logic [2:0] REG_DATA   = 3'd4;
    localparam logic [2:0] REG_STATUS = 3'd5;
    localparam logic [2:0] REG_DIV_LO = 3'd6;
    localparam logic [2:0] REG_DIV_HI = 3'd7;

    // Status bit positions
    localparam int ST_FERR    = 0;
    localparam int ST_OERR    = 1;
    localparam int ST_RXIE    = 2;
    localparam int ST_FULL    = 3;
    localparam int ST_ONEFREE = 4;
    localparam int ST_EMPTY   = 5;
    localparam int ST_TXIE    = 6;
    localparam int ST_TXEMPTY = 7;

    localparam int TICKS_PER_BIT = 4;
    localparam int CHAR_BITS     = 8;

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_pkg::*;
#(
    parameter int W = CHAR_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         hold_empty,
    output logic         busy,
    output logic         txd
);
    localparam int PH_W  = $clog2(TICKS_PER_BIT);
    localparam int IDX_W = $clog2(W);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

    tx_state_e        state, state_nxt;
    logic [PH_W-1:0]  phase;
    logic [IDX_W-1:0] bit_idx;
    logic [W-1:0]     shreg;
    logic [W-1:0]     hold;
    logic             hold_valid;
    logic             bit_done;

    assign bit_done = tick && (phase == PH_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE:  if (tick && hold_valid)              state_nxt = TX_START;
            TX_START: if (bit_done)                        state_nxt = TX_DATA;
            TX_DATA:  if (bit_done && bit_idx == IDX_LAST) state_nxt = TX_STOP;
            TX_STOP:  if (bit_done)                        state_nxt = TX_IDLE;
            default:                                       state_nxt = TX_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase      <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            hold       <= '0;
            hold_valid <= 1'b0;
        end else begin
            if (load && !hold_valid) begin
                hold       <= load_data;
                hold_valid <= 1'b1;
            end else if (state == TX_IDLE && tick && hold_valid) begin
                shreg      <= hold;
                hold_valid <= 1'b0;
            end

            if (state == TX_IDLE) phase <= '0;
            else if (tick)        phase <= phase + 1'b1;

            if (state != TX_DATA) begin
                bit_idx <= '0;
            end else if (bit_done) begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= shreg >> 1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    assign hold_empty = !hold_valid;
    assign busy       = (state != TX_IDLE);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_pkg::*;
#(
    parameter int W = CHAR_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rxd,
    output logic         push,
    output logic [W-1:0] push_data,
    output logic         frame_err
);
    localparam int PH_W  = $clog2(TICKS_PER_BIT);
    localparam int IDX_W = $clog2(W);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

    rx_state_e        state, state_nxt;
    logic [1:0]       sync;
    logic             rx_s;
    logic             prev_s;
    logic [PH_W-1:0]  phase;
    logic [IDX_W-1:0] bit_idx;
    logic [W-1:0]     shreg;
    logic             sample;

    assign rx_s   = sync[1];
    assign sample = tick && (phase == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && prev_s && !rx_s)       state_nxt = RX_START;
            RX_START: if (tick)                          state_nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (sample && bit_idx == IDX_LAST) state_nxt = RX_STOP;
            RX_STOP:  if (sample)                        state_nxt = RX_IDLE;
            default:                                     state_nxt = RX_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_s  <= 1'b1;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (tick) prev_s <= rx_s;

            if (state_nxt != state) phase <= '0;
            else if (tick)          phase <= phase + 1'b1;

            if (state != RX_DATA) begin
                bit_idx <= '0;
            end else if (sample) begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= {rx_s, shreg[W-1:1]};
            end
        end
    end

    // outputs
    assign push      = (state == RX_STOP) && sample;
    assign push_data = shreg;
    assign frame_err = !rx_s;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             one_free,
    output logic             push_ok
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_ok;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign one_free = (count == CNT_W'(DEPTH - 1));
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && (!full || pop_ok);
    assign head     = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/byte_uart.sv
module byte_uart
    import uart_pkg::*;
#(
    parameter int unsigned RESET_DIV  = 3,
    parameter int          FIFO_DEPTH = 4,
    parameter logic [31:0] ID_WORD    = 32'h5A3C01A7,
    localparam int DIV_W = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RESET_DIV);

    logic [7:0]       id_byte [4];
    logic             addr_ok;
    logic [2:0]       idx;
    logic             wr_data, wr_status, wr_div_lo, wr_div_hi, rd_pop;
    logic [7:0]       div_lo, div_hi;
    logic             rx_ie, tx_ie, ferr_flag, oerr_flag;
    logic             tick;
    logic             tx_hold_empty, tx_busy;
    logic             rx_push, rx_frame_err;
    logic [7:0]       rx_data;
    logic [7:0]       fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_empty, fifo_full, fifo_one_free, fifo_push_ok;
    logic             ferr_set, oerr_set;
    logic [7:0]       status;

    for (genvar g = 0; g < 4; g++) begin : g_id
        assign id_byte[g] = ID_WORD[8*g +: 8];
    end

    // address decode
    assign addr_ok   = (bus_addr[1:0] == 2'b00);
    assign idx       = bus_addr[4:2];
    assign wr_data   = bus_wr && addr_ok && (idx == REG_DATA);
    assign wr_status = bus_wr && addr_ok && (idx == REG_STATUS);
    assign wr_div_lo = bus_wr && addr_ok && (idx == REG_DIV_LO);
    assign wr_div_hi = bus_wr && addr_ok && (idx == REG_DIV_HI);
    assign rd_pop    = bus_rd && addr_ok && (idx == REG_DATA);

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor ({div_hi, div_lo}),
        .tick    (tick)
    );

    uart_tx_fsm #(.W(CHAR_BITS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (wr_data),
        .load_data  (bus_wdata),
        .hold_empty (tx_hold_empty),
        .busy       (tx_busy),
        .txd        (txd)
    );

    uart_rx_fsm #(.W(CHAR_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .push      (rx_push),
        .push_data (rx_data),
        .frame_err (rx_frame_err)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_BITS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rd_pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .one_free  (fifo_one_free),
        .push_ok   (fifo_push_ok)
    );

    assign ferr_set = rx_push && rx_frame_err;
    assign oerr_set = rx_push && !fifo_push_ok;

    // control / status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lo    <= DIV_INIT[7:0];
            div_hi    <= DIV_INIT[15:8];
            rx_ie     <= 1'b0;
            tx_ie     <= 1'b0;
            ferr_flag <= 1'b0;
            oerr_flag <= 1'b0;
        end else begin
            if (wr_div_lo) div_lo <= bus_wdata;
            if (wr_div_hi) div_hi <= bus_wdata;
            if (wr_status) begin
                rx_ie <= bus_wdata[ST_RXIE];
                tx_ie <= bus_wdata[ST_TXIE];
            end
            ferr_flag <= (wr_status ? (ferr_flag & bus_wdata[ST_FERR]) : ferr_flag) | ferr_set;
            oerr_flag <= (wr_status ? (oerr_flag & bus_wdata[ST_OERR]) : oerr_flag) | oerr_set;
        end
    end

    always_comb begin
        status             = '0;
        status[ST_FERR]    = ferr_flag;
        status[ST_OERR]    = oerr_flag;
        status[ST_RXIE]    = rx_ie;
        status[ST_FULL]    = fifo_full;
        status[ST_ONEFREE] = fifo_one_free;
        status[ST_EMPTY]   = fifo_empty;
        status[ST_TXIE]    = tx_ie;
        status[ST_TXEMPTY] = tx_hold_empty;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            unique case (idx)
                REG_DATA:   bus_rdata = fifo_head;
                REG_STATUS: bus_rdata = status;
                REG_DIV_LO: bus_rdata = div_lo;
                REG_DIV_HI: bus_rdata = div_hi;
                default:    bus_rdata = id_byte[idx[1:0]];
            endcase
        end
    end

    assign irq = (rx_ie && (!fifo_empty || ferr_flag || oerr_flag))
              || (tx_ie && tx_hold_empty);
endmodule

// File: rtl/uart_checker.sv
module uart_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             tx_busy,
    input logic             irq,
    input logic             rxie,
    input logic             txie,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             pop_req,
    input logic             push_req,
    input logic             oerr,
    input logic             ferr,
    input logic             ferr_set,
    input logic             status_wr,
    input logic             wdata0
);
    // R4: line high whenever the transmitter is idle
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R6: occupancy never exceeds the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R6: a read of an empty FIFO with no arrival leaves it empty
    a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fifo_empty && !push_req) |=> fifo_empty);

    // R7: overrun only rises when the FIFO was full
    a_r7_oerr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> $past(fifo_full));

    // R9: writing 1 never sets the frame-error flag
    a_r9_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && wdata0 && !ferr && !ferr_set) |=> !ferr);

    // R10: no interrupt with both enables off
    a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxie && !txie) |-> !irq);
endmodule

bind byte_uart uart_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd        (txd),
    .tx_busy    (tx_busy),
    .irq        (irq),
    .rxie       (rx_ie),
    .txie       (tx_ie),
    .fifo_count (fifo_count),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .pop_req    (rd_pop),
    .push_req   (rx_push),
    .oerr       (oerr_flag),
    .ferr       (ferr_flag),
    .ferr_set   (ferr_set),
    .status_wr  (wr_status),
    .wdata0     (bus_wdata[0])
);

// File: tb/tb_byte_uart.sv
`timescale 1ns/1ps
module tb_byte_uart;
    localparam int BIT_CLK = 16; // default divisor 3 -> 4 ticks of 4 clocks
    localparam logic [4:0] A_DATA = 5'd16, A_STAT = 5'd20, A_DLO = 5'd24, A_DHI = 5'd28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;
    int         checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    byte_uart dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] d, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic capture_frame(output logic [7:0] d, output logic ok);
        int n = 0;
        logic st, sp;
        while (txd !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
        repeat (7) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLK) @(negedge clk);
            d[i] = txd;
        end
        repeat (BIT_CLK) @(negedge clk);
        sp = txd;
        ok = (st == 1'b0) && (sp == 1'b1) && (n < 3000);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        bus_read(A_STAT, s);
        chk("R2 status", s, 8'hA0);
        chk("R2 irq", irq, 1'b0);
        chk("R2 txd", txd, 1'b1);
        bus_read(A_DLO, s);
        chk("R2 div low", s, 8'd3);
    endtask

    task automatic t_ids();
        logic [7:0] v;
        bus_read(5'd0, v);  chk("R1 id0", v, 8'hA7);
        bus_read(5'd4, v);  chk("R1 id1", v, 8'h01);
        bus_read(5'd8, v);  chk("R1 id2", v, 8'h3C);
        bus_read(5'd12, v); chk("R1 id3", v, 8'h5A);
        bus_read(5'd21, v); chk("R1 misaligned", v, 8'h00);
    endtask

    task automatic t_tx_frame();
        logic [7:0] d;
        logic ok;
        fork
            capture_frame(d, ok);
            bus_write(A_DATA, 8'h4B);
        join
        chk("R4 frame ok", ok, 1'b1);
        chk("R4 data lsb first", d, 8'h4B);
    endtask

    task automatic t_baud();
        logic [7:0] v;
        int n = 0, low = 0;
        bus_write(A_DHI, 8'h00);
        bus_write(A_DLO, 8'h07);
        bus_read(A_DLO, v); chk("R3 div low readback", v, 8'h07);
        bus_read(A_DHI, v); chk("R3 div high readback", v, 8'h00);
        bus_write(A_DATA, 8'h01);
        while (txd !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
        while (txd === 1'b0 && low < 1000) begin low++; @(negedge clk); end
        chk("R3 start bit length", low, 32);
        repeat (10 * 32) @(negedge clk);
        bus_write(A_DLO, 8'h03);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_tx_hold();
        logic [7:0] d1, d2, s;
        logic ok1, ok2;
        int n;
        fork
            begin
                capture_frame(d1, ok1);
                capture_frame(d2, ok2);
            end
            begin
                bus_write(A_DATA, 8'h3C);
                bus_read(A_STAT, s);
                chk("R5 slot full after write", s[7], 1'b0);
                n = 0;
                do begin bus_read(A_STAT, s); n++; end while (!s[7] && n < 20);
                chk("R5 slot freed by shifter", s[7], 1'b1);
                bus_write(A_DATA, 8'hC3);
                bus_write(A_DATA, 8'h99);
                bus_read(A_STAT, s);
                chk("R5 slot full second", s[7], 1'b0);
            end
        join
        chk("R5 first frame", {ok1, d1}, {1'b1, 8'h3C});
        chk("R5 second frame", {ok2, d2}, {1'b1, 8'hC3});
        n = 0;
        repeat (300) begin @(negedge clk); if (txd !== 1'b1) n++; end
        chk("R5 ignored write not sent", n, 0);
        bus_read(A_STAT, s);
        chk("R5 slot empty at end", s[7], 1'b1);
    endtask

    task automatic t_rx_fifo();
        logic [7:0] v;
        send_rx(8'h11, 1'b1); send_rx(8'h22, 1'b1); send_rx(8'h33, 1'b1);
        bus_read(A_STAT, v); chk("R6 one free", v, 8'h90);
        send_rx(8'h44, 1'b1);
        bus_read(A_STAT, v); chk("R6 full", v, 8'h88);
        bus_read(A_DATA, v); chk("R6 pop 1", v, 8'h11);
        bus_read(A_STAT, v); chk("R6 after pop", v, 8'h90);
        bus_read(A_DATA, v); chk("R6 pop 2", v, 8'h22);
        bus_read(A_DATA, v); chk("R6 pop 3", v, 8'h33);
        bus_read(A_DATA, v); chk("R6 pop 4", v, 8'h44);
        bus_read(A_STAT, v); chk("R6 empty", v, 8'hA0);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_rx(8'h55, 1'b1); send_rx(8'h66, 1'b1); send_rx(8'h77, 1'b1);
        send_rx(8'h88, 1'b1); send_rx(8'h99, 1'b1);
        bus_read(A_STAT, v); chk("R7 overrun flag", v, 8'h8A);
        bus_read(A_DATA, v); chk("R7 kept 1", v, 8'h55);
        bus_read(A_DATA, v); chk("R7 kept 2", v, 8'h66);
        bus_read(A_DATA, v); chk("R7 kept 3", v, 8'h77);
        bus_read(A_DATA, v); chk("R7 kept 4", v, 8'h88);
        bus_read(A_STAT, v); chk("R7 drained, flag held", v, 8'hA2);
        bus_write(A_STAT, 8'hFD);
        bus_read(A_STAT, v); chk("R9 overrun cleared", v, 8'hE4);
        bus_write(A_STAT, 8'h00);
    endtask

    task automatic t_frame_err();
        logic [7:0] v;
        send_rx(8'hE7, 1'b0);
        bus_read(A_STAT, v); chk("R8 frame error", v, 8'h81);
        bus_read(A_DATA, v); chk("R8 char stored", v, 8'hE7);
    endtask

    task automatic t_status_write();
        logic [7:0] v;
        bus_write(A_STAT, 8'hFF);
        bus_read(A_STAT, v); chk("R9 write ones keeps flags", v, 8'hE5);
        bus_write(A_STAT, 8'hFE);
        bus_read(A_STAT, v); chk("R9 frame error cleared", v, 8'hE4);
        @(negedge clk);
        chk("R10 tx irq", irq, 1'b1);
    endtask

    task automatic t_irq_rx();
        logic [7:0] v;
        bus_write(A_STAT, 8'h04);
        @(negedge clk);
        chk("R10 irq quiet", irq, 1'b0);
        send_rx(8'h5A, 1'b1);
        chk("R10 rx irq", irq, 1'b1);
        bus_read(A_DATA, v);
        chk("R10 rx data", v, 8'h5A);
        @(negedge clk);
        chk("R10 irq after drain", irq, 1'b0);
        bus_write(A_STAT, 8'h00);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CLK) @(negedge clk);
        bus_read(A_STAT, v); chk("R11 glitch rejected", v, 8'hA0);
        send_rx(8'h0F, 1'b1);
        bus_read(A_DATA, v); chk("R11 receiver still works", v, 8'h0F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_ids();
        t_tx_frame();
        t_baud();
        t_tx_hold();
        t_rx_fifo();
        t_overrun();
        t_frame_err();
        t_status_write();
        t_irq_rx();
        t_glitch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule